// File: doc/BRIEF.md
# Micro-second channel downstream serializer

This block turns queued words into downstream frames on a three-wire synchronous link: a serial clock, one data line and a set of chip-select lines. It sends two frame kinds. A command frame starts with a single 1 bit and carries either one command entry or two consecutive entries joined together. A data frame starts with zero, one or two 0 bits and carries a configurable number of payload bits from a data word. The bit order of the payload can be chosen. The marker bits are always sent ahead of the payload bits they introduce.

For a link that feeds two receivers, the block can drive one chip-select pattern during the first part of a data frame and a second pattern for the rest. When two data marker bits are configured in this mode, the second one opens the second part. After each frame the line rests for a programmable gap. The serial clock is made from the system clock by a programmable divider and rests low. Requests are taken through valid/ready handshakes. A command wins over data when both are waiting. A request that arrives during a frame waits until that frame and its gap are over.

Top module: `msc_down_tx`

## Requirements
- R1: After reset sck, sout, busy and done are 0, every chip-select line is at its inactive level (0 with the default polarity), cmd_ready is 1 and dat_ready follows !cmd_valid.
- R2: A command frame is the bit 1 followed by CMD_W payload bits taken from cmd_word. When cmd_cont is 1 on an accepted entry, no frame starts yet. The next accepted entry supplies the upper CMD_W bits of a 2*CMD_W-bit payload, and the held entry supplies the lower bits.
- R3: A data frame begins with cfg_sel_cnt marker bits driven as 0, where 0, 1 or 2 is taken as given and 3 acts as 2. These are followed by cfg_data_len payload bits from dat_word bits [cfg_data_len-1:0]. The valid lengths are 4 to DW.
- R4: With cfg_lsb_first=1 the payload goes out bit 0 first. With cfg_lsb_first=0 it goes out bit len-1 first. Marker bits precede the payload in both orders.
- R5: During the bits of a frame, cs equals cfg_cs_a. For a data frame with cfg_dual=1, cs switches to cfg_cs_b after cfg_split+1 payload bits. If two markers are configured in that mode, only the first leads the frame and the second is sent under cfg_cs_b just before the remaining payload. If the payload is not longer than cfg_split+1, there is no second part and no second marker. Command frames never switch.
- R6: Each bit lasts two half periods of cfg_div+1 system clocks each. sck is low in the first half and high in the second. sout changes only when sck falls or the frame starts. sck is low whenever no bit is being sent.
- R7: After the last bit, a gap of 2*(cfg_gap+1)*(cfg_div+1) system clocks follows. During the gap sck and sout are 0 and cs is inactive.
- R8: busy is 1 from the first cycle of the first bit to the last cycle of the gap. done is 1 for exactly the first cycle of the gap.
- R9: cmd_ready and dat_ready are 0 while busy is 1. A request held through a frame is taken in the first cycle after the gap, and its frame starts one cycle after acceptance.
- R10: When cmd_valid and dat_valid are both 1 in an idle cycle, the command is taken first (dat_ready is 0 whenever cmd_valid is 1).
- R11: While the second entry of a joined command is awaited, dat_ready is 0 and the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Half period of sck minus one, in system clocks |
| cfg_lsb_first | input | 1 | 1: payload least significant bit first |
| cfg_sel_cnt | input | 2 | Number of data marker bits (3 acts as 2) |
| cfg_data_len | input | LEN_W | Data payload length in bits, 4 to DW |
| cfg_dual | input | 1 | Enable mid-frame chip-select switch for data frames |
| cfg_split | input | LEN_W | Payload bits in the first part, minus one |
| cfg_cs_a | input | NCS | Chip-select pattern for the first part |
| cfg_cs_b | input | NCS | Chip-select pattern for the second part |
| cfg_gap | input | GAP_W | Gap length in sck periods, minus one |
| cmd_valid | input | 1 | Command entry offered |
| cmd_ready | output | 1 | Command entry can be taken |
| cmd_word | input | CMD_W | Command entry bits |
| cmd_cont | input | 1 | Entry is the lower half of a joined command |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word can be taken |
| dat_word | input | DW | Data payload word |
| sck | output | 1 | Serial clock, rests low |
| sout | output | 1 | Serial data |
| cs | output | NCS | Chip-select lines |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with its defaults: a 32-bit data word, 16-bit command entries, two chip-select lines and 8-bit divider. With those values, a single command gives a 16-bit payload and a joined command fills the whole 32-bit word. The two chip-select lines let the bench give the two patterns values that differ on every line. The bench varies the divider from 0 to 2 and the gap from 0 to 3, so that the half-period and gap arithmetic is checked at more than one size. It sweeps data lengths from the minimum of 4 to the full 32, and it places the split point before the end of the payload, so that the second-part marker appears, and also past the end, so that no second part exists.

// File: rtl/msc_tx_pkg.sv
package msc_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD2,
      ST_SEL,
      ST_PAY,
      ST_GAP
   } tx_state_t;

   typedef enum logic [1:0] {
      LD_CMD1,
      LD_CMD2,
      LD_DATA
   } ld_kind_t;

   // marker count: code 3 behaves as 2
   function automatic logic [1:0] clamp_sel(input logic [1:0] s);
      return (s == 2'd3) ? 2'd2 : s;
   endfunction

endpackage

// File: rtl/msc_half_tick.sv
module msc_half_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == div);

   a_r6_tick_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/msc_bit_shifter.sv
module msc_bit_shifter #(
   parameter int DW    = 32,
   parameter int LEN_W = $clog2(DW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DW-1:0]    load_word,
   input  logic [LEN_W-1:0] load_len,
   input  logic             lsb_first,
   input  logic             shift,
   output logic             bit_out
);
   logic [DW-1:0] sh;
   int            align;

   always_comb align = DW - int'(load_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else if (load) begin
         if (lsb_first) sh <= load_word;
         else           sh <= load_word << align;
      end else if (shift) begin
         if (lsb_first) sh <= sh >> 1;
         else           sh <= sh << 1;
      end
   end

   assign bit_out = lsb_first ? sh[0] : sh[DW-1];

   a_r4_no_load_and_shift : assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/msc_frame_seq.sv
module msc_frame_seq
   import msc_tx_pkg::*;
#(
   parameter int LEN_W = 6,
   parameter int GAP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_valid,
   input  logic             cmd_cont,
   input  logic             dat_valid,
   input  logic             cfg_dual,
   input  logic [1:0]       cfg_sel_cnt,
   input  logic [LEN_W-1:0] cfg_split,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic [LEN_W-1:0] start_len,
   output tx_state_t        st,
   output logic             hi,
   output logic             is_cmd,
   output logic             in_b,
   output logic             cmd_ready,
   output logic             dat_ready,
   output logic             load,
   output logic             hold_first,
   output logic             shift,
   output logic             done,
   output ld_kind_t         ld_kind
);
   logic             acc_cmd, acc_dat, start_cmd;
   logic [LEN_W-1:0] pay_left, part_cnt;
   logic [1:0]       sel_left, sc;
   logic             sel2_pend;
   logic [GAP_W:0]   gap_left;
   logic             in_frame, in_busy;

   assign in_frame  = (st == ST_SEL) || (st == ST_PAY);
   assign in_busy   = in_frame || (st == ST_GAP);
   assign cmd_ready = (st == ST_IDLE) || (st == ST_CMD2);
   assign dat_ready = (st == ST_IDLE) && !cmd_valid;
   assign acc_cmd   = cmd_valid && cmd_ready;
   assign acc_dat   = dat_valid && dat_ready;
   assign start_cmd = acc_cmd && ((st == ST_CMD2) || !cmd_cont);
   assign hold_first = acc_cmd && (st == ST_IDLE) && cmd_cont;
   assign load      = start_cmd || acc_dat;
   assign shift     = (st == ST_PAY) && tick && hi;
   assign sc        = clamp_sel(cfg_sel_cnt);

   always_comb begin
      if (st == ST_CMD2)  ld_kind = LD_CMD2;
      else if (cmd_valid) ld_kind = LD_CMD1;
      else                ld_kind = LD_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         hi        <= 1'b0;
         is_cmd    <= 1'b0;
         in_b      <= 1'b0;
         pay_left  <= '0;
         part_cnt  <= '0;
         sel_left  <= '0;
         sel2_pend <= 1'b0;
         gap_left  <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE, ST_CMD2: begin
               if (hold_first) begin
                  st <= ST_CMD2;
               end else if (load) begin
                  hi       <= 1'b0;
                  in_b     <= 1'b0;
                  part_cnt <= '0;
                  pay_left <= start_len;
                  is_cmd   <= start_cmd;
                  if (start_cmd) begin
                     sel_left  <= 2'd1;
                     sel2_pend <= 1'b0;
                     st        <= ST_SEL;
                  end else if (cfg_dual && sc == 2'd2) begin
                     sel_left  <= 2'd1;
                     sel2_pend <= 1'b1;
                     st        <= ST_SEL;
                  end else begin
                     sel_left  <= sc;
                     sel2_pend <= 1'b0;
                     st        <= (sc == 2'd0) ? ST_PAY : ST_SEL;
                  end
               end
            end
            ST_SEL: begin
               if (tick) begin
                  hi <= !hi;
                  if (hi) begin
                     sel_left <= sel_left - 1'b1;
                     if (sel_left == 2'd1) st <= ST_PAY;
                  end
               end
            end
            ST_PAY: begin
               if (tick) begin
                  hi <= !hi;
                  if (hi) begin
                     pay_left <= pay_left - 1'b1;
                     part_cnt <= part_cnt + 1'b1;
                     if (pay_left == LEN_W'(1)) begin
                        st       <= ST_GAP;
                        gap_left <= {cfg_gap, 1'b1};
                        done     <= 1'b1;
                     end else if (!is_cmd && cfg_dual && !in_b && part_cnt == cfg_split) begin
                        in_b <= 1'b1;
                        if (sel2_pend) begin
                           sel2_pend <= 1'b0;
                           sel_left  <= 2'd1;
                           st        <= ST_SEL;
                        end
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_left == '0) st <= ST_IDLE;
                  else                gap_left <= gap_left - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_in_gap : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (st == ST_GAP));
   a_r9_hold_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
      in_busy |-> (!cmd_ready && !dat_ready));
   a_r10_cmd_first : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !dat_ready);
   a_r11_wait_second : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD2) |-> (!dat_ready && !hi));
   a_r6_rest_low : assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> !hi);
   a_r5_cmd_no_switch : assert property (@(posedge clk) disable iff (!rst_n)
      in_b |-> !is_cmd);
endmodule

// File: rtl/msc_down_tx.sv
module msc_down_tx
   import msc_tx_pkg::*;
#(
   parameter int DW            = 32,
   parameter int CMD_W         = 16,
   parameter int NCS           = 2,
   parameter int DIV_W         = 8,
   parameter int GAP_W         = 6,
   parameter bit CS_ACTIVE_LOW = 1'b0,
   parameter int LEN_W         = $clog2(DW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_lsb_first,
   input  logic [1:0]       cfg_sel_cnt,
   input  logic [LEN_W-1:0] cfg_data_len,
   input  logic             cfg_dual,
   input  logic [LEN_W-1:0] cfg_split,
   input  logic [NCS-1:0]   cfg_cs_a,
   input  logic [NCS-1:0]   cfg_cs_b,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic             cmd_cont,
   input  logic             dat_valid,
   output logic             dat_ready,
   input  logic [DW-1:0]    dat_word,
   output logic             sck,
   output logic             sout,
   output logic [NCS-1:0]   cs,
   output logic             busy,
   output logic             done
);
   if (2 * CMD_W > DW) begin : g_bad_cmd
      $error("msc_down_tx: two command entries must fit in DW");
   end
   if (CMD_W < 4 || NCS < 1 || DIV_W < 1 || GAP_W < 1) begin : g_bad_size
      $error("msc_down_tx: parameter out of range");
   end

   tx_state_t        st;
   ld_kind_t         ld_kind;
   logic             hi, is_cmd, in_b, load, hold_first, shift, tick;
   logic             bit_out, run;
   logic [CMD_W-1:0] first_q;
   logic [DW-1:0]    ld_word;
   logic [LEN_W-1:0] ld_len;
   logic [NCS-1:0]   cs_raw;

   assign run = (st == ST_SEL) || (st == ST_PAY) || (st == ST_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          first_q <= '0;
      else if (hold_first) first_q <= cmd_word;
   end

   always_comb begin
      case (ld_kind)
         LD_CMD1: begin
            ld_word = DW'(cmd_word);
            ld_len  = LEN_W'(CMD_W);
         end
         LD_CMD2: begin
            ld_word = DW'({cmd_word, first_q});
            ld_len  = LEN_W'(2 * CMD_W);
         end
         default: begin
            ld_word = dat_word;
            ld_len  = cfg_data_len;
         end
      endcase
   end

   msc_half_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (cfg_div),
      .tick (tick)
   );

   msc_frame_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cmd_valid  (cmd_valid),
      .cmd_cont   (cmd_cont),
      .dat_valid  (dat_valid),
      .cfg_dual   (cfg_dual),
      .cfg_sel_cnt(cfg_sel_cnt),
      .cfg_split  (cfg_split),
      .cfg_gap    (cfg_gap),
      .start_len  (ld_len),
      .st         (st),
      .hi         (hi),
      .is_cmd     (is_cmd),
      .in_b       (in_b),
      .cmd_ready  (cmd_ready),
      .dat_ready  (dat_ready),
      .load       (load),
      .hold_first (hold_first),
      .shift      (shift),
      .done       (done),
      .ld_kind    (ld_kind)
   );

   msc_bit_shifter #(.DW(DW), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_word(ld_word),
      .load_len (ld_len),
      .lsb_first(cfg_lsb_first),
      .shift    (shift),
      .bit_out  (bit_out)
   );

   assign sck  = hi;
   assign busy = run;

   always_comb begin
      case (st)
         ST_SEL:  sout = is_cmd;
         ST_PAY:  sout = bit_out;
         default: sout = 1'b0;
      endcase
   end

   assign cs_raw = ((st == ST_SEL) || (st == ST_PAY)) ? (in_b ? cfg_cs_b : cfg_cs_a) : '0;

   if (CS_ACTIVE_LOW) begin : g_cs_low
      assign cs = ~cs_raw;
   end else begin : g_cs_high
      assign cs = cs_raw;
   end

   a_r6_hold_while_high : assert property (@(posedge clk) disable iff (!rst_n)
      (sck && !tick) |=> $stable(sout));
   a_r7_gap_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sck && (st == ST_GAP)) |-> (!sout && cs_raw == '0));
   a_r8_done_busy : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: tb/sim_msc_down_tx.sv
module sim_msc_down_tx;
   localparam int DW = 32, CMD_W = 16, NCS = 2, DIV_W = 8, GAP_W = 6;
   localparam int LEN_W = $clog2(DW + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             cfg_lsb_first = 1'b1;
   logic [1:0]       cfg_sel_cnt = '0;
   logic [LEN_W-1:0] cfg_data_len = LEN_W'(8);
   logic             cfg_dual = 1'b0;
   logic [LEN_W-1:0] cfg_split = '0;
   logic [NCS-1:0]   cfg_cs_a = 2'b01;
   logic [NCS-1:0]   cfg_cs_b = 2'b10;
   logic [GAP_W-1:0] cfg_gap = '0;
   logic             cmd_valid = 1'b0, cmd_cont = 1'b0, dat_valid = 1'b0;
   logic [CMD_W-1:0] cmd_word = '0;
   logic [DW-1:0]    dat_word = '0;
   logic             cmd_ready, dat_ready, sck, sout, busy, done;
   logic [NCS-1:0]   cs;

   int checks = 0, errors = 0, cyc = 0;
   string cur_tag = "R1";
   logic [5:0] exp_q[$];
   logic       waiting = 1'b0;
   logic [CMD_W-1:0] held = '0;

   always #2 clk = ~clk;

   msc_down_tx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_lsb_first(cfg_lsb_first),
      .cfg_sel_cnt(cfg_sel_cnt), .cfg_data_len(cfg_data_len), .cfg_dual(cfg_dual),
      .cfg_split(cfg_split), .cfg_cs_a(cfg_cs_a), .cfg_cs_b(cfg_cs_b), .cfg_gap(cfg_gap),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_cont(cmd_cont),
      .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
      .sck(sck), .sout(sout), .cs(cs), .busy(busy), .done(done)
   );

   // expected cycle trace of one frame: {sck, sout, cs, busy, done}
   task automatic build_frame(input bit cmdf, input logic [DW-1:0] w, input int len);
      bit bq[$];
      bit cq[$];
      int sc, first, sec, d, bidx;
      if (cmdf) begin
         first = 1; sec = 0;
      end else begin
         sc = (cfg_sel_cnt == 2'd3) ? 2 : int'(cfg_sel_cnt);
         if (cfg_dual && sc == 2) begin first = 1; sec = 1; end
         else begin first = sc; sec = 0; end
      end
      for (int i = 0; i < first; i++) begin bq.push_back(cmdf); cq.push_back(1'b0); end
      for (int i = 0; i < len; i++) begin
         bit partb;
         partb = !cmdf && cfg_dual && (i >= int'(cfg_split) + 1);
         if (!cmdf && cfg_dual && i == int'(cfg_split) + 1 && sec == 1) begin
            bq.push_back(1'b0); cq.push_back(1'b1);
         end
         bidx = cfg_lsb_first ? i : len - 1 - i;
         bq.push_back(w[bidx]); cq.push_back(partb);
      end
      d = int'(cfg_div) + 1;
      foreach (bq[k])
         for (int h = 0; h < 2; h++)
            for (int r = 0; r < d; r++)
               exp_q.push_back({h[0], bq[k], (cq[k] ? cfg_cs_b : cfg_cs_a), 1'b1, 1'b0});
      for (int g = 0; g < 2 * (int'(cfg_gap) + 1) * d; g++)
         exp_q.push_back({1'b0, 1'b0, 2'b00, 1'b1, (g == 0)});
   endtask

   // reference model, compared every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [5:0] e, a;
         logic er_c, er_d;
         cyc++;
         a = {sck, sout, cs, busy, done};
         if (exp_q.size() == 0) begin
            e = '0;
            er_c = 1'b1;
            er_d = !waiting && !cmd_valid;
         end else begin
            e = exp_q.pop_front();
            er_c = 1'b0;
            er_d = 1'b0;
         end
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s cycle %0d lines {sck,sout,cs,busy,done} got %b exp %b", cur_tag, cyc, a, e);
         end
         checks++;
         if ({cmd_ready, dat_ready} !== {er_c, er_d}) begin
            errors++;
            $display("FAIL %s R9/R10/R11 cycle %0d ready got %b exp %b", cur_tag, cyc,
                     {cmd_ready, dat_ready}, {er_c, er_d});
         end
         if (er_c) begin
            if (cmd_valid) begin
               if (waiting) begin
                  build_frame(1'b1, DW'({cmd_word, held}), 2 * CMD_W);
                  waiting = 1'b0;
               end else if (cmd_cont) begin
                  held = cmd_word;
                  waiting = 1'b1;
               end else build_frame(1'b1, DW'(cmd_word), CMD_W);
            end else if (dat_valid && !waiting) begin
               build_frame(1'b0, dat_word, int'(cfg_data_len));
            end
         end
      end
   end

   task automatic send_cmd(input logic [CMD_W-1:0] w, input logic cont);
      @(posedge clk); #1;
      cmd_word = w; cmd_cont = cont; cmd_valid = 1'b1;
      do @(negedge clk); while (!cmd_ready);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic send_dat(input logic [DW-1:0] w);
      @(posedge clk); #1;
      dat_word = w; dat_valid = 1'b1;
      do @(negedge clk); while (!dat_ready);
      @(posedge clk); #1;
      dat_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (exp_q.size() != 0 || busy || waiting);
      repeat (2) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset lines", {2'b0, sck, sout, cs, busy, done}, 8'h00);
      chk("R1 reset ready", {6'b0, cmd_ready, dat_ready}, 8'h03);

      cur_tag = "R2 R6 R7 R8 single command";
      @(posedge clk); #1;
      cfg_div = 0; cfg_gap = 1; cfg_lsb_first = 1;
      send_cmd(16'hA5C3, 1'b0);
      wait_idle();

      cur_tag = "R2 R4 R11 joined command msb first";
      cfg_lsb_first = 0; cfg_div = 1;
      fork
         begin
            send_cmd(16'h1234, 1'b1);
            repeat (4) @(posedge clk);
            send_cmd(16'hBEEF, 1'b0);
         end
         begin
            repeat (2) @(posedge clk);
            send_dat(32'h0000_00F0);
         end
      join
      wait_idle();

      cur_tag = "R3 R4 data no marker lsb";
      cfg_lsb_first = 1; cfg_sel_cnt = 0; cfg_data_len = 8; cfg_div = 0; cfg_gap = 0;
      send_dat(32'h0000_00B6);
      wait_idle();

      cur_tag = "R3 R4 R6 data one marker full width msb";
      cfg_lsb_first = 0; cfg_sel_cnt = 1; cfg_data_len = 32; cfg_div = 2; cfg_gap = 3;
      send_dat(32'hC001_D00D);
      wait_idle();

      cur_tag = "R3 two markers code 3 minimum length";
      cfg_lsb_first = 1; cfg_sel_cnt = 3; cfg_data_len = 4; cfg_div = 1; cfg_gap = 0;
      send_dat(32'h0000_000B);
      wait_idle();

      cur_tag = "R5 dual two markers split";
      cfg_dual = 1; cfg_sel_cnt = 2; cfg_split = 3; cfg_data_len = 12; cfg_div = 0;
      send_dat(32'h0000_0E5A);
      wait_idle();

      cur_tag = "R5 R4 dual one marker msb";
      cfg_sel_cnt = 1; cfg_split = 5; cfg_data_len = 10; cfg_lsb_first = 0; cfg_cs_a = 2'b11; cfg_cs_b = 2'b00;
      send_dat(32'h0000_02C9);
      wait_idle();

      cur_tag = "R5 dual no second part";
      cfg_sel_cnt = 2; cfg_split = 20; cfg_data_len = 8; cfg_cs_a = 2'b01; cfg_cs_b = 2'b10;
      send_dat(32'h0000_0071);
      wait_idle();

      cur_tag = "R5 command ignores dual";
      cfg_split = 1;
      send_cmd(16'h0F0F, 1'b0);
      wait_idle();

      cur_tag = "R10 command before data";
      cfg_dual = 0; cfg_sel_cnt = 1; cfg_lsb_first = 1; cfg_data_len = 16; cfg_gap = 2;
      fork
         send_cmd(16'h8001, 1'b0);
         send_dat(32'h0000_5AA5);
      join
      wait_idle();

      cur_tag = "R9 request held during frame";
      cfg_div = 1;
      fork
         send_dat(32'h0000_F00F);
         begin
            repeat (10) @(posedge clk);
            send_cmd(16'h3C3C, 1'b0);
         end
      join
      wait_idle();
      chk("R8 R9 back to idle", {5'b0, busy, cmd_ready, dat_ready}, 8'h03);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule